// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off pattern for a crossbar of 12 rows by 8 columns. Each of the 96 crosspoints has one state bit. A 1 closes that crosspoint and a 0 opens it. The bank is write-only. The caller places a row code, a column code and a data bit on the inputs, then raises a strobe. The one cell that the address names takes the data bit for as long as the strobe stays high. That cell keeps the last value it took once the strobe falls. No other cell changes.

The row code is four bits wide, but only twelve rows exist. The code splits into a bank bit (the top bit) and a three-bit offset within the bank. Offsets 0 to 5 are real rows and offsets 6 and 7 are holes. A strobe on a hole code alters nothing. A high level on the clear input empties the entire bank at once, with no clock edge needed, and it overrides any strobe in progress.

The cells are transparent latches in concept. Here they are built as registers sampled by the system clock, which must be much faster than the strobe. A cell therefore follows the data bit on every clock edge at which the strobe is high. Each new value reaches the output one clock later. Address, data and strobe are taken to be synchronous to that clock.

Top module: `xbar_cell_bank`

## Requirements
- R1: Row code `rowAddr` values 0..5 select rows 0..5 and values 8..13 select rows 6..11. `colAddr` selects columns 0..7. The cell at row r, column c drives `switchOn[c*12 + r]`, and a stored 1 in that cell means the crosspoint is on.
- R2: A strobe with row code 6, 7, 14 or 15 leaves every bit of `switchOn` unchanged, whatever the column code and data.
- R3: At each rising clock edge where `strobeIn` is high and `clearIn` is low, the addressed cell takes `dataIn`. The new value appears on `switchOn` right after that edge, so `dataIn` toggling under a held strobe is followed with a one-cycle lag.
- R4: After `strobeIn` falls, the addressed cell keeps the value it took at the last clock edge with `strobeIn` high, even if `dataIn` changes later.
- R5: A write changes at most one bit of `switchOn` per clock: the addressed cell. All other cells keep their state.
- R6: While `strobeIn` is low, changes on `rowAddr`, `colAddr` and `dataIn` leave `switchOn` unchanged.
- R7: Raising `clearIn` drives all 96 bits of `switchOn` to 0 straight away, without waiting for a clock edge. The bank stays empty for as long as `clearIn` is high. Holding `clearIn` high at power-up gives the all-off start state.
- R8: When `clearIn` and a strobed write on a valid address are active together, the clear wins and the addressed cell stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the cells |
| clearIn | input | 1 | Asynchronous clear, active high, empties all cells |
| rowAddr | input | 4 | Row code: bank bit on top, three-bit offset below |
| colAddr | input | 3 | Column code 0..7 |
| dataIn | input | 1 | Value written to the addressed cell |
| strobeIn | input | 1 | Write enable, active high |
| switchOn | output | 96 | Crosspoint states, bit c*12+r for row r, column c |

## Verification
The hardest case to reach from the ports is a cell that must follow `dataIn` through several values under one long strobe and then keep only the last one. The stimulus holds the strobe for many cycles on a single address and toggles the data bit every clock. It then drops the strobe and changes data and address again. The asynchronous clear is raised between clock edges and the output is sampled before the next edge, so an edge-synchronous clear cannot hide. The bench also walks all sixteen row codes against every column code and keeps a behavioural model in step with the bank on every clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Default geometry of the crosspoint bank
  localparam int ROW_COUNT  = 12;
  localparam int COL_COUNT  = 8;
  localparam int ROW_ADDR_W = 4;
  localparam int COL_ADDR_W = 3;
  localparam int LOW_W      = 3;   // offset bits within one row bank

  localparam int BANK_COUNT = 2 ** (ROW_ADDR_W - LOW_W);
  localparam int BANK_ROWS  = ROW_COUNT / BANK_COUNT;
  localparam int CELL_COUNT = ROW_COUNT * COL_COUNT;
  localparam int ROW_IDX_W  = $clog2(ROW_COUNT);
  localparam int CELL_IDX_W = $clog2(CELL_COUNT);

  // Strobes handed from the address decoder to the cell bank
  typedef struct packed {
    logic                  writeEn;
    logic [ROW_IDX_W-1:0]  rowSel;
    logic [COL_ADDR_W-1:0] colSel;
    logic                  dataBit;
  } cellCmd_t;

endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int ROW_AW   = ROW_ADDR_W,
  parameter int COL_AW   = COL_ADDR_W,
  parameter int OFFS_W   = LOW_W,
  parameter int PER_BANK = BANK_ROWS
) (
  input  logic              clearIn,
  input  logic [ROW_AW-1:0] rowAddr,
  input  logic [COL_AW-1:0] colAddr,
  input  logic              dataIn,
  input  logic              strobeIn,
  output cellCmd_t          cmd
);

  localparam int BANK_W = ROW_AW - OFFS_W;

  logic [OFFS_W-1:0] offsetPart;
  logic [BANK_W-1:0] bankPart;
  logic              rowHit;
  logic [ROW_IDX_W-1:0] rowLinear;

  always_comb begin
    offsetPart = rowAddr[OFFS_W-1:0];
    bankPart   = rowAddr[ROW_AW-1:OFFS_W];
    // offsets past the rows of one bank are holes
    rowHit     = (offsetPart < OFFS_W'(PER_BANK));
    rowLinear  = ROW_IDX_W'(bankPart) * ROW_IDX_W'(PER_BANK)
               + ROW_IDX_W'(offsetPart);
  end

  always_comb begin
    cmd.writeEn = strobeIn & rowHit & ~clearIn;   // clear dominates (R8)
    cmd.rowSel  = rowLinear;
    cmd.colSel  = colAddr;
    cmd.dataBit = dataIn;
  end

endmodule

// File: rtl/xbar_cells.sv
module xbar_cells
  import xbar_pkg::*;
#(
  parameter int NUM_ROWS = ROW_COUNT,
  parameter int NUM_COLS = COL_COUNT
) (
  input  logic                         clk,
  input  logic                         clearIn,
  input  cellCmd_t                     cmd,
  output logic [NUM_ROWS*NUM_COLS-1:0] cellState
);

  localparam int NUM_CELLS = NUM_ROWS * NUM_COLS;
  localparam int IDX_W     = $clog2(NUM_CELLS);

  logic [NUM_ROWS-1:0] rowOneHot;
  logic [NUM_COLS-1:0] colOneHot;

  // Split row/column decode, combined per cell below
  genvar r, c;
  generate
    for (r = 0; r < NUM_ROWS; r++) begin : gRowDec
      assign rowOneHot[r] = cmd.writeEn && (cmd.rowSel == ROW_IDX_W'(r));
    end
    for (c = 0; c < NUM_COLS; c++) begin : gColDec
      assign colOneHot[c] = (cmd.colSel == COL_ADDR_W'(c));
    end

    for (c = 0; c < NUM_COLS; c++) begin : gCol
      for (r = 0; r < NUM_ROWS; r++) begin : gRow
        logic cellQ;
        logic cellHit;
        assign cellHit = rowOneHot[r] & colOneHot[c];
        // latch modelled as a register sampled by the fast clock
        always_ff @(posedge clk or posedge clearIn) begin
          if (clearIn)      cellQ <= 1'b0;
          else if (cellHit) cellQ <= cmd.dataBit;
        end
        assign cellState[c*NUM_ROWS + r] = cellQ;
      end
    end
  endgenerate

  logic [IDX_W-1:0] writeIdx;
  assign writeIdx = IDX_W'(cmd.colSel) * IDX_W'(NUM_ROWS) + IDX_W'(cmd.rowSel);

  // R3: a strobed cell holds the sampled data bit after the edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (clearIn)
    $past(cmd.writeEn) |-> cellState[$past(writeIdx)] == $past(cmd.dataBit));

  // R5: no more than one cell moves per clock
  assert_single_cell_R5: assert property (@(posedge clk) disable iff (clearIn)
    $countones(cellState ^ $past(cellState)) <= 1);

  // R6: without a write strobe the bank is frozen
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (clearIn)
    !$past(cmd.writeEn) |-> cellState == $past(cellState));

  // R7: a clear seen at one edge leaves the bank empty at the next
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (clearIn)
    $past(clearIn) |-> cellState == '0);

endmodule

// File: rtl/xbar_cell_bank.sv
module xbar_cell_bank
  import xbar_pkg::*;
(
  input  logic                  clk,
  input  logic                  clearIn,
  input  logic [ROW_ADDR_W-1:0] rowAddr,
  input  logic [COL_ADDR_W-1:0] colAddr,
  input  logic                  dataIn,
  input  logic                  strobeIn,
  output logic [CELL_COUNT-1:0] switchOn
);

  cellCmd_t cmd;

  xbar_ctrl #(
    .ROW_AW  (ROW_ADDR_W),
    .COL_AW  (COL_ADDR_W),
    .OFFS_W  (LOW_W),
    .PER_BANK(BANK_ROWS)
  ) uCtrl (
    .clearIn (clearIn),
    .rowAddr (rowAddr),
    .colAddr (colAddr),
    .dataIn  (dataIn),
    .strobeIn(strobeIn),
    .cmd     (cmd)
  );

  xbar_cells #(
    .NUM_ROWS(ROW_COUNT),
    .NUM_COLS(COL_COUNT)
  ) uCells (
    .clk      (clk),
    .clearIn  (clearIn),
    .cmd      (cmd),
    .cellState(switchOn)
  );

  // R2: a strobe on a hole row code changes nothing
  assert_hole_inert_R2: assert property (@(posedge clk) disable iff (clearIn)
    ($past(strobeIn) && ($past(rowAddr[LOW_W-1:0]) >= LOW_W'(BANK_ROWS)))
      |-> switchOn == $past(switchOn));

endmodule

// File: tb/sim_xbar_cell_bank.sv
`timescale 1ns/1ps
module sim_xbar_cell_bank;

  localparam int NR = 12;
  localparam int NC = 8;
  localparam int NCELL = NR * NC;

  logic             clk = 1'b0;
  logic             clearIn = 1'b1;
  logic [3:0]       rowAddr = '0;
  logic [2:0]       colAddr = '0;
  logic             dataIn = 1'b0;
  logic             strobeIn = 1'b0;
  logic [NCELL-1:0] switchOn;

  logic [NCELL-1:0] expBank = '0;
  int checks = 0;
  int fails = 0;
  string curReq = "R7";

  always #10 clk = ~clk;   // 50 MHz

  xbar_cell_bank u0 (
    .clk(clk), .clearIn(clearIn), .rowAddr(rowAddr), .colAddr(colAddr),
    .dataIn(dataIn), .strobeIn(strobeIn), .switchOn(switchOn)
  );

  // Row number for a row code, -1 for codes with no row
  function automatic int rowOf(input int code);
    int offs = code % 8;
    if (offs >= 6) return -1;
    return (code / 8) * 6 + offs;
  endfunction

  task automatic compareAll();
    checks++;
    if (switchOn !== expBank) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", curReq, switchOn, expBank);
    end
  endtask

  task automatic checkBit(input string req, input int idx, input logic want);
    checks++;
    if (switchOn[idx] !== want) begin
      fails++;
      $display("FAIL %s: bit %0d actual %b expected %b", req, idx, switchOn[idx], want);
    end
  endtask

  // One clock: update the model from the inputs at the edge, then compare
  task automatic tick();
    int r;
    @(posedge clk);
    r = rowOf(int'(rowAddr));
    if (clearIn) expBank = '0;
    else if (strobeIn && r >= 0) expBank[int'(colAddr) * NR + r] = dataIn;
    @(negedge clk);
    compareAll();
  endtask

  task automatic drive(input int r, input int c, input logic d, input logic s);
    rowAddr = 4'(r); colAddr = 3'(c); dataIn = d; strobeIn = s;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R7: power-up with clear held
    curReq = "R7";
    repeat (3) tick();
    checks++;
    if (switchOn !== '0) begin
      fails++;
      $display("FAIL R7: reset state actual %h expected 0", switchOn);
    end
    clearIn = 1'b0;
    tick();

    // R1 / R2: walk every row code and column code, writing ones
    curReq = "R1";
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < 16; r++) begin
        drive(r, c, 1'b1, 1'b1);
        tick();
        drive(r, c, 1'b0, 1'b0);
        tick();
      end
    end
    checkBit("R1", 0, 1'b1);
    checkBit("R1", 95, 1'b1);
    checkBit("R1", 6, 1'b1);
    checks++;
    if (switchOn !== '1) begin
      fails++;
      $display("FAIL R1: all-on actual %h expected all ones", switchOn);
    end

    // R7: asynchronous clear between edges
    curReq = "R7";
    #5 clearIn = 1'b1;
    #1;
    checks++;
    if (switchOn !== '0) begin
      fails++;
      $display("FAIL R7: async clear actual %h expected 0", switchOn);
    end
    expBank = '0;
    tick();
    clearIn = 1'b0;
    tick();

    // R2: hole codes with data 1 write nothing
    curReq = "R2";
    for (int c = 0; c < NC; c++) begin
      foreach (rowAddr[k]) begin end
      drive(6, c, 1'b1, 1'b1); tick();
      drive(7, c, 1'b1, 1'b1); tick();
      drive(14, c, 1'b1, 1'b1); tick();
      drive(15, c, 1'b1, 1'b1); tick();
    end
    drive(0, 0, 1'b0, 1'b0); tick();
    checks++;
    if (switchOn !== '0) begin
      fails++;
      $display("FAIL R2: hole writes actual %h expected 0", switchOn);
    end

    // R1: a single targeted write lands at col*12+row
    curReq = "R1";
    drive(9, 3, 1'b1, 1'b1); tick();
    drive(9, 3, 1'b0, 1'b0); tick();
    checkBit("R1", 3 * NR + 7, 1'b1);

    // R3 / R4: held strobe, data toggling each clock, then release
    curReq = "R3";
    drive(12, 5, 1'b0, 1'b1);
    for (int i = 0; i < 9; i++) begin
      dataIn = (i % 2 == 0);
      tick();
      checkBit("R3", 5 * NR + 10, (i % 2 == 0));
    end
    curReq = "R4";
    strobeIn = 1'b0; dataIn = 1'b0; tick();
    rowAddr = 4'd1; dataIn = 1'b1; tick();
    checkBit("R4", 5 * NR + 10, 1'b1);

    // R6: address and data wander with strobe low
    curReq = "R6";
    for (int i = 0; i < 40; i++) begin
      drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), 1'b0);
      tick();
    end
    checkBit("R6", 3 * NR + 7, 1'b1);

    // R8: clear together with a valid strobe
    curReq = "R8";
    clearIn = 1'b1;
    drive(2, 1, 1'b1, 1'b1);
    repeat (3) tick();
    checkBit("R8", 1 * NR + 2, 1'b0);
    strobeIn = 1'b0;
    clearIn = 1'b0;
    tick();
    checkBit("R8", 1 * NR + 2, 1'b0);

    // R5: random strobed traffic, model compared every clock
    curReq = "R5";
    for (int i = 0; i < 600; i++) begin
      drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
      tick();
    end
    strobeIn = 1'b0;
    tick();

    summary();
    $finish;
  end

endmodule